// File: doc/BRIEF.md
# Chip Erase and Verify Sequencer

This block sits on the host side of a command-driven parallel flash and runs a complete chip-erase algorithm with no help from software beyond a start pulse. The run has three phases. First, every byte in the array is programmed to 00h with a byte-program engine that retries on a bad read-back. Next, the sequencer issues an erase by writing the erase opcode twice and waiting out the erase interval. Finally, it checks the array one byte at a time with margin-verify reads.

When a verify read does not return FFh, the sequencer keeps the current byte address and counts the failure. It then erases again and resumes verify at the kept address, so bytes that already passed are not checked again. The run ends with a pass after the last byte reads FFh; the sequencer then puts the flash back into read mode. The run ends with a fail when a byte cannot be pre-programmed, or when the erase-retry budget is used up. The array size, the retry limits and every wait interval are parameters counted in clock cycles.

The flash side is a simple synchronous strobe bus. A one-cycle write strobe carries an address and a data byte. A one-cycle read strobe carries an address, and the read data comes back later with a valid pulse.

Top module: `chip_erase_seq`

## Requirements
- R1: A start pulse while idle raises busy in the next cycle and begins the run. A start pulse while busy has no effect on the bus traffic or on the result.
- R2: Pre-program covers addresses 0 to NUM_BYTES-1 in ascending order. Each attempt is four bus operations: a write of 40h, a write of data 00h to the byte address, a write of C0h, and a read of the byte address.
- R3: A pre-program read-back other than 00h repeats the attempt from the 40h write, up to PROG_MAX attempts per byte. If the last attempt also fails, the run ends with fail, retry count 0, and no erase write.
- R4: After the last byte is pre-programmed, the block writes 20h twice in consecutive bus operations, starting one erase.
- R5: Each verify step writes A0h with the byte address and then reads that same address.
- R6: A byte passes verify only when it reads FFh. Verify starts at address 0 and steps up by one after each pass.
- R7: On a verify read other than FFh, the retry count goes up by one, a new erase (20h, 20h) is issued, and verify resumes at the same address, not at 0.
- R8: When the retry count reaches ERASE_MAX, the run ends with fail and no further bus operation. No erase and no read-mode write follow.
- R9: When the last address passes verify, the block writes 00h (read mode) and ends with pass. The retry count then equals the number of failed verify reads.
- R10: done is a one-cycle pulse with exactly one of pass or fail set. pass, fail and retry_cnt hold until the next start, and a new start clears them.
- R11: The bus operation after the second 20h write follows at least ERASE_WAIT and at most ERASE_WAIT+3 cycles later. The operation after the 00h data write follows PROG_WAIT to PROG_WAIT+3 cycles later. The read after an A0h or C0h write follows VERIFY_WAIT to VERIFY_WAIT+3 cycles later.
- R12: After reset, busy, done, pass, fail, retry_cnt and both bus strobes are 0.
- R13: At most one bus strobe is high in any cycle, and no bus operation occurs outside a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a full erase run |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Last run erased and verified the whole array |
| fail | output | 1 | Last run ended in a pre-program or erase-retry failure |
| retry_cnt | output | $clog2(ERASE_MAX+1) | Number of failed verify reads in the last run |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe, one cycle per read |
| fl_addr | output | $clog2(NUM_BYTES) | Flash byte address |
| fl_wdata | output | 8 | Flash write data or command opcode |
| fl_rvalid | input | 1 | Read data valid pulse |
| fl_rdata | input | 8 | Read data byte |

## Verification
The assertions check the following on every cycle:
- the write and read strobes are never high together, and the bus is quiet between runs;
- a verdict always comes with done;
- erase starts only after a successful pre-program;
- the per-byte attempt counter and the erase-retry counter stay within their limits;
- the retry counter moves only by single steps, and the verify address never steps back during a run;
- every read is launched by an expired wait timer.

Only the bench's scenarios can show the full ordering of commands and addresses, and the resume-at-kept-address rule under a byte that needs several erases. They also cover the two failure exits and their exact final bus state, the wait windows, and the neutrality of a start pulse given mid-run.

// File: rtl/ces_pkg.sv
package ces_pkg;
  // command opcodes understood by the flash command register
  localparam logic [7:0] OP_READ     = 8'h00;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_PROGRAM  = 8'h40;
  localparam logic [7:0] OP_EVERIFY  = 8'hA0;
  localparam logic [7:0] OP_PVERIFY  = 8'hC0;

  localparam logic [7:0] BYTE_CLEAR  = 8'h00;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;

  typedef enum logic [1:0] {PH_IDLE, PH_PREPROG, PH_ERASE} phase_t;
  typedef enum logic [2:0] {BP_IDLE, BP_LOAD, BP_PWAIT, BP_VWAIT, BP_READ} bp_state_t;
  typedef enum logic [2:0] {EV_IDLE, EV_CONFIRM, EV_EWAIT, EV_VWAIT, EV_READ} ev_state_t;
endpackage

// File: rtl/ces_timer.sv
module ces_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (load) begin
        cnt <= len;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == W'(1)) expired <= 1'b1;
      end
    end
  end

  AST_TIMER_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    expired |=> !expired);  // R11
  AST_TIMER_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && !load) |=> (cnt == '0 && !expired));  // R11
endmodule

// File: rtl/ces_byte_prog.sv
module ces_byte_prog
  import ces_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int PROG_MAX    = 25,
  parameter int PROG_WAIT   = 500,
  parameter int VERIFY_WAIT = 300,
  localparam int WMAX = (PROG_WAIT > VERIFY_WAIT) ? PROG_WAIT : VERIFY_WAIT,
  localparam int TW   = $clog2(WMAX + 1),
  localparam int TRW  = $clog2(PROG_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        data_in,
  output logic              done,
  output logic              ok,
  output logic              bus_we,
  output logic              bus_re,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              rvalid,
  input  logic [7:0]        rdata
);
  bp_state_t         st;
  logic [ADDR_W-1:0] a_q;
  logic [7:0]        d_q;
  logic [TRW-1:0]    tries;
  logic              tmr_load;
  logic [TW-1:0]     tmr_len;
  logic              tmr_exp;

  always_comb begin
    tmr_load = (st == BP_LOAD) || (st == BP_PWAIT && tmr_exp);
    tmr_len  = (st == BP_LOAD) ? TW'(PROG_WAIT) : TW'(VERIFY_WAIT);
  end

  ces_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= BP_IDLE;
      done      <= 1'b0;
      ok        <= 1'b0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      a_q       <= '0;
      d_q       <= '0;
      tries     <= '0;
    end else begin
      done   <= 1'b0;
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      case (st)
        BP_IDLE: begin
          if (start) begin
            a_q       <= addr_in;
            d_q       <= data_in;
            tries     <= '0;
            bus_we    <= 1'b1;
            bus_addr  <= addr_in;
            bus_wdata <= OP_PROGRAM;
            st        <= BP_LOAD;
          end
        end
        BP_LOAD: begin
          bus_we    <= 1'b1;
          bus_addr  <= a_q;
          bus_wdata <= d_q;
          st        <= BP_PWAIT;
        end
        BP_PWAIT: begin
          if (tmr_exp) begin
            bus_we    <= 1'b1;
            bus_wdata <= OP_PVERIFY;
            st        <= BP_VWAIT;
          end
        end
        BP_VWAIT: begin
          if (tmr_exp) begin
            bus_re   <= 1'b1;
            bus_addr <= a_q;
            st       <= BP_READ;
          end
        end
        BP_READ: begin
          if (rvalid) begin
            tries <= tries + 1'b1;
            if (rdata == d_q) begin
              done <= 1'b1;
              ok   <= 1'b1;
              st   <= BP_IDLE;
            end else if (int'(tries) + 1 >= PROG_MAX) begin
              done <= 1'b1;
              ok   <= 1'b0;
              st   <= BP_IDLE;
            end else begin
              bus_we    <= 1'b1;
              bus_wdata <= OP_PROGRAM;
              st        <= BP_LOAD;
            end
          end
        end
        default: st <= BP_IDLE;
      endcase
    end
  end

  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(tries) <= PROG_MAX);  // R3
  AST_PREAD_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    bus_re |-> $past(tmr_exp));  // R11
endmodule

// File: rtl/ces_erase_verify.sv
module ces_erase_verify
  import ces_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int NUM_BYTES   = 262144,
  parameter int ERASE_MAX   = 1000,
  parameter int ERASE_WAIT  = 500000,
  parameter int VERIFY_WAIT = 300,
  localparam int WMAX = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT,
  localparam int TW   = $clog2(WMAX + 1),
  localparam int CW   = $clog2(ERASE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              pass,
  output logic [CW-1:0]     ecnt,
  output logic              bus_we,
  output logic              bus_re,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              rvalid,
  input  logic [7:0]        rdata
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_BYTES - 1);

  ev_state_t         st;
  logic [ADDR_W-1:0] vaddr;
  logic              tmr_load;
  logic [TW-1:0]     tmr_len;
  logic              tmr_exp;
  logic              byte_ok;

  always_comb begin
    byte_ok  = (rdata == BYTE_ERASED);
    tmr_load = (st == EV_CONFIRM) || (st == EV_EWAIT && tmr_exp) ||
               (st == EV_READ && rvalid && byte_ok && vaddr != LAST);
    tmr_len  = (st == EV_CONFIRM) ? TW'(ERASE_WAIT) : TW'(VERIFY_WAIT);
  end

  ces_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= EV_IDLE;
      done      <= 1'b0;
      pass      <= 1'b0;
      ecnt      <= '0;
      vaddr     <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      done   <= 1'b0;
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      case (st)
        EV_IDLE: begin
          if (start) begin
            vaddr     <= '0;
            ecnt      <= '0;
            bus_we    <= 1'b1;
            bus_wdata <= OP_ERASE;
            st        <= EV_CONFIRM;
          end
        end
        EV_CONFIRM: begin
          bus_we    <= 1'b1;
          bus_wdata <= OP_ERASE;
          st        <= EV_EWAIT;
        end
        EV_EWAIT: begin
          if (tmr_exp) begin
            bus_we    <= 1'b1;
            bus_addr  <= vaddr;
            bus_wdata <= OP_EVERIFY;
            st        <= EV_VWAIT;
          end
        end
        EV_VWAIT: begin
          if (tmr_exp) begin
            bus_re   <= 1'b1;
            bus_addr <= vaddr;
            st       <= EV_READ;
          end
        end
        EV_READ: begin
          if (rvalid) begin
            if (byte_ok) begin
              if (vaddr == LAST) begin
                bus_we    <= 1'b1;
                bus_wdata <= OP_READ;
                done      <= 1'b1;
                pass      <= 1'b1;
                st        <= EV_IDLE;
              end else begin
                vaddr     <= vaddr + 1'b1;
                bus_we    <= 1'b1;
                bus_addr  <= vaddr + 1'b1;
                bus_wdata <= OP_EVERIFY;
                st        <= EV_VWAIT;
              end
            end else begin
              ecnt <= ecnt + 1'b1;
              if (int'(ecnt) + 1 >= ERASE_MAX) begin
                done <= 1'b1;
                pass <= 1'b0;
                st   <= EV_IDLE;
              end else begin
                bus_we    <= 1'b1;
                bus_wdata <= OP_ERASE;
                st        <= EV_CONFIRM;
              end
            end
          end
        end
        default: st <= EV_IDLE;
      endcase
    end
  end

  AST_ECNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(ecnt) <= ERASE_MAX);  // R8
  AST_ECNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (st != EV_IDLE) |=> (ecnt == $past(ecnt) || ecnt == $past(ecnt) + 1'b1));  // R7
  AST_RESUME_NO_BACKSTEP: assert property (@(posedge clk) disable iff (rst)
    (st != EV_IDLE && $past(st) != EV_IDLE) |-> (vaddr >= $past(vaddr)));  // R7
  AST_VREAD_AFTER_WAIT: assert property (@(posedge clk) disable iff (rst)
    bus_re |-> $past(tmr_exp));  // R5
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq
  import ces_pkg::*;
#(
  parameter int NUM_BYTES   = 262144,
  parameter int PROG_MAX    = 25,
  parameter int ERASE_MAX   = 1000,
  parameter int PROG_WAIT   = 500,
  parameter int ERASE_WAIT  = 500000,
  parameter int VERIFY_WAIT = 300,
  localparam int ADDR_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int CW     = $clog2(ERASE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [CW-1:0]     retry_cnt,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic              fl_rvalid,
  input  logic [7:0]        fl_rdata
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_BYTES - 1);

  phase_t            phase;
  logic [ADDR_W-1:0] pre_addr;
  logic              pg_start, ev_start;

  logic              pg_done, pg_ok, pg_we, pg_re;
  logic [ADDR_W-1:0] pg_addr;
  logic [7:0]        pg_wdata;
  logic              ev_done, ev_pass, ev_we, ev_re;
  logic [CW-1:0]     ev_cnt;
  logic [ADDR_W-1:0] ev_addr;
  logic [7:0]        ev_wdata;
  logic              sel_pre;

  assign sel_pre = (phase == PH_PREPROG);

  ces_byte_prog #(
    .ADDR_W(ADDR_W), .PROG_MAX(PROG_MAX),
    .PROG_WAIT(PROG_WAIT), .VERIFY_WAIT(VERIFY_WAIT)
  ) u_prog (
    .clk(clk), .rst(rst), .start(pg_start),
    .addr_in(pre_addr), .data_in(BYTE_CLEAR),
    .done(pg_done), .ok(pg_ok),
    .bus_we(pg_we), .bus_re(pg_re), .bus_addr(pg_addr), .bus_wdata(pg_wdata),
    .rvalid(fl_rvalid & sel_pre), .rdata(fl_rdata)
  );

  ces_erase_verify #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .ERASE_MAX(ERASE_MAX),
    .ERASE_WAIT(ERASE_WAIT), .VERIFY_WAIT(VERIFY_WAIT)
  ) u_erase (
    .clk(clk), .rst(rst), .start(ev_start),
    .done(ev_done), .pass(ev_pass), .ecnt(ev_cnt),
    .bus_we(ev_we), .bus_re(ev_re), .bus_addr(ev_addr), .bus_wdata(ev_wdata),
    .rvalid(fl_rvalid & ~sel_pre), .rdata(fl_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      pre_addr  <= '0;
      pg_start  <= 1'b0;
      ev_start  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      retry_cnt <= '0;
      fl_we     <= 1'b0;
      fl_re     <= 1'b0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
    end else begin
      pg_start <= 1'b0;
      ev_start <= 1'b0;
      done     <= 1'b0;
      fl_we    <= sel_pre ? pg_we    : ev_we;
      fl_re    <= sel_pre ? pg_re    : ev_re;
      fl_addr  <= sel_pre ? pg_addr  : ev_addr;
      fl_wdata <= sel_pre ? pg_wdata : ev_wdata;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            busy      <= 1'b1;
            pass      <= 1'b0;
            fail      <= 1'b0;
            retry_cnt <= '0;
            pre_addr  <= '0;
            pg_start  <= 1'b1;
            phase     <= PH_PREPROG;
          end
        end
        PH_PREPROG: begin
          if (pg_done) begin
            if (!pg_ok) begin
              fail  <= 1'b1;
              done  <= 1'b1;
              busy  <= 1'b0;
              phase <= PH_IDLE;
            end else if (pre_addr == LAST) begin
              ev_start <= 1'b1;
              phase    <= PH_ERASE;
            end else begin
              pre_addr <= pre_addr + 1'b1;
              pg_start <= 1'b1;
            end
          end
        end
        PH_ERASE: begin
          if (ev_done) begin
            pass      <= ev_pass;
            fail      <= ~ev_pass;
            retry_cnt <= ev_cnt;
            done      <= 1'b1;
            busy      <= 1'b0;
            phase     <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re));  // R13
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !(fl_we || fl_re));  // R13
  AST_DONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass ^ fail));  // R10
  AST_ERASE_AFTER_PREPROGRAM: assert property (@(posedge clk) disable iff (rst)
    ev_start |-> $past(pg_done && pg_ok));  // R4
endmodule

// File: tb/chip_erase_seq_tb.sv
module chip_erase_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int PMAX = 3;
  localparam int EMAX = 4;
  localparam int PW   = 5;
  localparam int EW   = 20;
  localparam int VW   = 3;
  localparam int AW   = $clog2(N);
  localparam int CW   = $clog2(EMAX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, pass, fail;
  logic [CW-1:0] retry_cnt;
  logic fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata;
  logic fl_rvalid = 1'b0;
  logic [7:0] fl_rdata = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  chip_erase_seq #(
    .NUM_BYTES(N), .PROG_MAX(PMAX), .ERASE_MAX(EMAX),
    .PROG_WAIT(PW), .ERASE_WAIT(EW), .VERIFY_WAIT(VW)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .retry_cnt(retry_cnt),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t", req, act, act, exp, exp, $time);
    end
  endtask

  // expected bus operations: kind 0 = command write (data only), 1 = write with address, 2 = read
  int    q_kind[$];
  int    q_addr[$];
  int    q_data[$];
  int    q_gap[$];
  string q_req[$];

  int pneed[N];
  int eneed[N];

  // behavioural flash model state
  int  pc[N];
  int  erases;
  bit  pend_prog;
  bit  setup20;
  int  cmd;
  bit  mon_on = 1'b0;
  int  cyc = 0;
  int  last_op = 0;

  task automatic push(input int k, input int a, input int d, input int g, input string r);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d);
    q_gap.push_back(g);  q_req.push_back(r);
  endtask

  task automatic build(output bit exp_pass, output int exp_retry);
    int a, e, er;
    bit first;
    q_kind.delete(); q_addr.delete(); q_data.delete(); q_gap.delete(); q_req.delete();
    for (int b = 0; b < N; b++) begin
      for (int t = 1; ; t++) begin
        push(0, b, 8'h40, 0, "R2");
        push(1, b, 8'h00, 0, "R2");
        push(0, 0, 8'hC0, PW, "R11");
        push(2, b, 0, VW, "R2");
        if (t >= pneed[b]) break;
        if (t >= PMAX) begin
          exp_pass = 0; exp_retry = 0;
          return;
        end
      end
    end
    a = 0; e = 0; er = 0;
    forever begin
      push(0, 0, 8'h20, 0, "R4");
      push(0, 0, 8'h20, 0, "R4");
      er++;
      first = 1;
      forever begin
        push(1, a, 8'hA0, first ? EW : 0, (e > 0 && first) ? "R7" : "R5");
        push(2, a, 0, VW, "R6");
        if (er >= eneed[a]) begin
          a++;
          first = 0;
          if (a == N) begin
            push(0, 0, 8'h00, 0, "R9");
            exp_pass = 1; exp_retry = e;
            return;
          end
        end else break;
      end
      e++;
      if (e >= EMAX) begin
        exp_pass = 0; exp_retry = e;
        return;
      end
    end
  endtask

  // monitor and flash model, evaluated away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      fl_rvalid = 1'b0;
      if (mon_on && (fl_we || fl_re)) begin
        if (q_kind.size() == 0) begin
          chk(0, "R13 unexpected bus op", int'(fl_wdata), -1);
        end else begin
          int k, a, d, g;
          string r;
          bit ok;
          k = q_kind.pop_front(); a = q_addr.pop_front(); d = q_data.pop_front();
          g = q_gap.pop_front();  r = q_req.pop_front();
          ok = 1;
          if (k == 2) ok = fl_re && !fl_we && (int'(fl_addr) == a);
          else        ok = fl_we && !fl_re && (int'(fl_wdata) == d) && (k == 0 || int'(fl_addr) == a);
          chk(ok, r, fl_re ? 1000 + int'(fl_addr) : int'(fl_wdata), (k == 2) ? 1000 + a : d);
          if (g > 0) chk((cyc - last_op >= g) && (cyc - last_op <= g + 3), "R11 wait window", cyc - last_op, g);
        end
        last_op = cyc;
      end
      if (fl_we) begin
        if (pend_prog) begin
          pc[fl_addr]++;
          pend_prog = 0;
        end else begin
          if (fl_wdata == 8'h20) begin
            if (setup20) begin erases++; setup20 = 0; end
            else setup20 = 1;
          end else setup20 = 0;
          if (fl_wdata == 8'h40) pend_prog = 1;
          cmd = int'(fl_wdata);
        end
      end
      if (fl_re) begin
        fl_rvalid = 1'b1;
        if (cmd == 8'hC0)      fl_rdata = (pc[fl_addr] >= pneed[fl_addr]) ? 8'h00 : 8'h10;
        else if (cmd == 8'hA0) fl_rdata = (erases >= eneed[fl_addr]) ? 8'hFF : 8'h00;
        else                   fl_rdata = 8'hFF;
      end
    end
  end

  task automatic run_case(input bit poke, input string vtag);
    bit ep;
    int er, k;
    build(ep, er);
    for (int i = 0; i < N; i++) pc[i] = 0;
    erases = 0; pend_prog = 0; setup20 = 0; cmd = 0;
    mon_on = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    chk(retry_cnt == '0 && !pass && !fail, "R10 cleared by start", int'(retry_cnt), 0);
    k = 0;
    while (!done) begin
      @(negedge clk);
      k++;
      start = (poke && k == 40) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    chk(pass == ep, vtag, int'(pass), int'(ep));
    chk(fail == !ep, "R10 fail flag", int'(fail), int'(!ep));
    chk(int'(retry_cnt) == er, ep ? "R9 retry count" : "R8 retry count", int'(retry_cnt), er);
    @(negedge clk);
    chk(done == 1'b0, "R10 done pulse width", int'(done), 0);
    repeat (30) @(negedge clk);
    chk(q_kind.size() == 0, "R13 missing bus ops", q_kind.size(), 0);
    chk(pass == ep && fail == !ep && int'(retry_cnt) == er, "R10 verdict held", int'(pass), int'(ep));
    chk(busy == 1'b0, "R1 busy drops", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin pneed[i] = 1; eneed[i] = 1; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !pass && !fail && retry_cnt == '0 && !fl_we && !fl_re,
        "R12 reset state", int'({busy, done, pass, fail, fl_we, fl_re}), 0);

    // clean array, single erase
    run_case(0, "R9 clean pass");

    // program retries, resume after extra erases, start poked mid-run (R1, R3, R7)
    pneed[2] = 3; eneed[0] = 1; eneed[5] = 3;
    run_case(1, "R7 resume pass");

    // pre-program exhaustion: no erase follows
    for (int i = 0; i < N; i++) begin pneed[i] = 1; eneed[i] = 1; end
    pneed[4] = PMAX + 1;
    run_case(0, "R3 preprogram fail");

    // erase budget exhausted
    pneed[4] = 1; eneed[3] = EMAX + 1;
    run_case(0, "R8 erase limit fail");

    // recovery run clears the previous verdict
    eneed[3] = EMAX; eneed[7] = 2;
    run_case(0, "R6 last-byte retry pass");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule